// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash device. It runs on a synchronous clock. For each single-cycle write strobe it receives an address and a data word. It tracks the unlock handshake that must come before any alteration of the array. When a sequence completes, it issues a decoded request for the array controller: word program, sector erase, block erase or whole-chip erase. The request carries the target address and data.

The same write stream also switches the read mode. Three-write sequences select identification mode or query mode. An exit command returns the block to normal array reads. In identification mode the block supplies the manufacturer and device codes on a read-data port. When the array controller raises `busy`, every incoming write is discarded and the sequence state and mode do not change.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (array read), `req_valid` is 0 and `id_data` is 0000h.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h and then any address/data issue a program request. `req_valid` is high in the cycle after the fourth strobe, with `req_op`=1, `req_addr` set to that address and `req_data` set to that data.
- R3: The erase path is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh. A sixth write of 30h at any address issues `req_op`=2, with `req_addr` equal to the address with bits 10..0 cleared (sector select from bits 17..11).
- R4: On the erase path, a sixth write of 50h issues `req_op`=3, with `req_addr` equal to the address with bits 14..0 cleared (block select from bits 17..15).
- R5: On the erase path, a sixth write of 10h at 5555h issues `req_op`=4 with `req_addr`=0. A 10h written anywhere else issues nothing.
- R6: Unlock steps compare only address bits 14..0 and data bits 7..0. Higher bits have no effect on the match.
- R7: After AAh@5555h and 55h@2AAAh, a third write of 90h@5555h sets `mode`=1 (identification) and 98h@5555h sets `mode`=2 (query). The new mode is visible in the cycle after the strobe.
- R8: A single write of F0h to any address, or the three-write sequence ending in F0h@5555h, sets `mode`=0.
- R9: Any write that does not match the expected step restarts the sequence and sets `mode`=0. No request is issued from a broken sequence.
- R10: While `busy` is high, a write has no effect. No request is issued, `mode` is kept, and the sequence position is kept, so the sequence continues with the next accepted write.
- R11: With `mode`=1 and `rd_addr` bits 17..1 all zero, `id_data` is 00BFh when bit 0 is 0 and 272Fh when bit 0 is 1. In every other case `id_data` is 0000h.
- R12: `req_valid` is high for exactly one cycle per completed command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | 18 | Write address |
| wr_data | input | 16 | Write data |
| busy | input | 1 | Internal program/erase in progress |
| rd_addr | input | 18 | Read address for identification codes |
| req_valid | output | 1 | One-cycle request pulse |
| req_op | output | 3 | Request type: 1 program, 2 sector, 3 block, 4 chip |
| req_addr | output | 18 | Request target address (region-aligned for erases) |
| req_data | output | 16 | Data of the final write |
| mode | output | 2 | 0 array read, 1 identification, 2 query |
| id_data | output | 16 | Identification code for `rd_addr` |

## Verification
The decoder is driven with the complete program and erase sequences. These show that each final code maps to its own request type and its own address alignment. The same sequences are repeated with the upper address and data bits set, which shows that only the low bits take part in matching. Broken sequences are applied: a wrong step deep in the erase path, a chip-erase code at the wrong address, and a stray write while in identification mode. These separate a true restart from a decoder that keeps partial progress. Writes made while `busy` is high are placed in the middle of an unlock and inside identification mode. They show that the write is dropped without disturbing the sequence position or the mode.

// File: rtl/nor_cmd_pkg.sv
// Shared types and command constants for the flash command decoder.
// Assumes unlock comparisons use 15 address bits and 8 data bits.
package nor_cmd_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PROG = 3'd1,
        OP_SECT = 3'd2,
        OP_BLK  = 3'd3,
        OP_CHIP = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        MODE_READ = 2'd0,
        MODE_ID   = 2'd1,
        MODE_CFI  = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_WORD,
        ST_ERA1,
        ST_ERA2,
        ST_ERA3
    } step_e;

    localparam logic [14:0] UNLOCK_ADDR_A = 15'h5555;
    localparam logic [14:0] UNLOCK_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_ERASE = 8'h80;
    localparam logic [7:0] CODE_IDENT = 8'h90;
    localparam logic [7:0] CODE_QUERY = 8'h98;
    localparam logic [7:0] CODE_EXIT  = 8'hF0;
    localparam logic [7:0] CODE_SECT  = 8'h30;
    localparam logic [7:0] CODE_BLK   = 8'h50;
    localparam logic [7:0] CODE_CHIP  = 8'h10;

endpackage

// File: rtl/nor_cmd_match.sv
// Compares the low address and data bits of a write against the unlock keys.
// Assumes the caller has already dropped the bits that take no part in matching.
module nor_cmd_match
    import nor_cmd_pkg::*;
#(
    parameter int CMP_ADDR_W = 15,
    parameter int CMP_DATA_W = 8
) (
    input  logic [CMP_ADDR_W-1:0] addr_lo,
    input  logic [CMP_DATA_W-1:0] data_lo,
    output logic                  at_addr_a,
    output logic                  at_addr_b,
    output logic [7:0]            code
);

    localparam logic [CMP_ADDR_W-1:0] KEY_A = CMP_ADDR_W'(UNLOCK_ADDR_A);
    localparam logic [CMP_ADDR_W-1:0] KEY_B = CMP_ADDR_W'(UNLOCK_ADDR_B);

    // Flag the two unlock addresses and present the command byte.
    always_comb begin
        at_addr_a = (addr_lo == KEY_A);
        at_addr_b = (addr_lo == KEY_B);
        code      = 8'(data_lo);
    end

endmodule

// File: rtl/nor_cmd_seq.sv
// Unlock sequence tracker, mode register and request register.
// Assumes wr_stb is a single-cycle pulse; busy blocks every write completely.
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 11,
    parameter int BLK_LSB  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              at_addr_a,
    input  logic              at_addr_b,
    input  logic [7:0]        code,
    output logic              req_valid,
    output logic [2:0]        req_op,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [1:0]        mode
);

    localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_LSB;
    localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_LSB;

    step_e             step_q, step_d;
    mode_e             mode_q, mode_d;
    logic              fire;
    op_e               fire_op;
    logic [ADDR_W-1:0] fire_addr;
    logic              accept;

    assign accept = wr_stb && !busy;

    // Next sequence step, next mode and any request from the accepted write.
    always_comb begin
        step_d    = step_q;
        mode_d    = mode_q;
        fire      = 1'b0;
        fire_op   = OP_NONE;
        fire_addr = wr_addr;
        if (accept) begin
            step_d = ST_IDLE;
            case (step_q)
                ST_IDLE: begin
                    if (at_addr_a && code == KEY_FIRST) step_d = ST_KEY1;
                    else                                mode_d = MODE_READ;
                end
                ST_KEY1: begin
                    if (at_addr_b && code == KEY_SECOND) step_d = ST_KEY2;
                    else                                 mode_d = MODE_READ;
                end
                ST_KEY2: begin
                    if (at_addr_a && code == CODE_PROG)       step_d = ST_WORD;
                    else if (at_addr_a && code == CODE_ERASE) step_d = ST_ERA1;
                    else if (at_addr_a && code == CODE_IDENT) mode_d = MODE_ID;
                    else if (at_addr_a && code == CODE_QUERY) mode_d = MODE_CFI;
                    else                                      mode_d = MODE_READ;
                end
                ST_WORD: begin
                    fire    = 1'b1;
                    fire_op = OP_PROG;
                end
                ST_ERA1: begin
                    if (at_addr_a && code == KEY_FIRST) step_d = ST_ERA2;
                    else                                mode_d = MODE_READ;
                end
                ST_ERA2: begin
                    if (at_addr_b && code == KEY_SECOND) step_d = ST_ERA3;
                    else                                 mode_d = MODE_READ;
                end
                ST_ERA3: begin
                    if (code == CODE_SECT) begin
                        fire      = 1'b1;
                        fire_op   = OP_SECT;
                        fire_addr = wr_addr & SECT_MASK;
                    end else if (code == CODE_BLK) begin
                        fire      = 1'b1;
                        fire_op   = OP_BLK;
                        fire_addr = wr_addr & BLK_MASK;
                    end else if (code == CODE_CHIP && at_addr_a) begin
                        fire      = 1'b1;
                        fire_op   = OP_CHIP;
                        fire_addr = '0;
                    end else begin
                        mode_d = MODE_READ;
                    end
                end
                default: mode_d = MODE_READ;
            endcase
        end
    end

    // Register the sequence step and the read mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
            mode_q <= MODE_READ;
        end else begin
            step_q <= step_d;
            mode_q <= mode_d;
        end
    end

    // Register the request as a one-cycle pulse with its payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_op    <= OP_NONE;
            req_addr  <= '0;
            req_data  <= '0;
        end else begin
            req_valid <= fire;
            if (fire) begin
                req_op   <= fire_op;
                req_addr <= fire_addr;
                req_data <= wr_data;
            end
        end
    end

    assign mode = mode_q;

    // R12
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(mode) && !req_valid));

    // R9
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(wr_stb && !busy));

    // R2
    req_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_op inside {OP_PROG, OP_SECT, OP_BLK, OP_CHIP}));

    // R3
    sect_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_SECT) |-> (req_addr[SECT_LSB-1:0] == '0));

    // R7
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);

endmodule

// File: rtl/nor_id_read.sv
// Returns the manufacturer or device code while identification mode is active.
// Assumes the codes sit at word 0 and word 1; all other reads give zero.
module nor_id_read #(
    parameter int          ADDR_W = 18,
    parameter int          DATA_W = 16,
    parameter logic [15:0] MFR_ID = 16'h00BF,
    parameter logic [15:0] DEV_ID = 16'h272F
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] id_data
);

    // Select the identification code from the read address.
    always_comb begin
        id_data = '0;
        if (id_mode && rd_addr[ADDR_W-1:1] == '0)
            id_data = rd_addr[0] ? DATA_W'(DEV_ID) : DATA_W'(MFR_ID);
    end

endmodule

// File: rtl/nor_cmd_decoder.sv
// Top of the flash command decoder: matcher, sequence tracker and ID read path.
// Assumes one write per strobe pulse and a busy flag from the array controller.
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int CMP_ADDR_W = 15,
    parameter int CMP_DATA_W = 8,
    parameter int SECT_LSB   = 11,
    parameter int BLK_LSB    = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              req_valid,
    output logic [2:0]        req_op,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [1:0]        mode,
    output logic [DATA_W-1:0] id_data
);

    logic       at_addr_a;
    logic       at_addr_b;
    logic [7:0] code;

    nor_cmd_match #(
        .CMP_ADDR_W (CMP_ADDR_W),
        .CMP_DATA_W (CMP_DATA_W)
    ) u_match (
        .addr_lo   (wr_addr[CMP_ADDR_W-1:0]),
        .data_lo   (wr_data[CMP_DATA_W-1:0]),
        .at_addr_a (at_addr_a),
        .at_addr_b (at_addr_b),
        .code      (code)
    );

    nor_cmd_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SECT_LSB (SECT_LSB),
        .BLK_LSB  (BLK_LSB)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .at_addr_a (at_addr_a),
        .at_addr_b (at_addr_b),
        .code      (code),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .mode      (mode)
    );

    nor_id_read #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_id (
        .id_mode (mode == MODE_ID),
        .rd_addr (rd_addr),
        .id_data (id_data)
    );

endmodule

// File: tb/nor_cmd_decoder_tb.sv
module nor_cmd_decoder_tb;

    localparam int NV = 63;
    localparam int VW = 79;

    // {addr18, data16, busy, exp_valid, exp_op3, exp_addr18, exp_data16, exp_mode2, req4}
    localparam logic [VW-1:0] VEC [0:NV-1] = '{
        // R2 program
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd2},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd2},
        {18'h05555,16'h00A0,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd2},
        {18'h31234,16'hBEEF,1'b0,1'b1,3'd1,18'h31234,16'hBEEF,2'd0,4'd2},
        // R6 upper bits ignored in unlock
        {18'h3D555,16'h12AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd6},
        {18'h0AAAA,16'hFF55,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd6},
        {18'h25555,16'h77A0,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd6},
        {18'h00010,16'h0001,1'b0,1'b1,3'd1,18'h00010,16'h0001,2'd0,4'd6},
        // R3 sector erase
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd3},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd3},
        {18'h05555,16'h0080,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd3},
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd3},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd3},
        {18'h23C7F,16'h0030,1'b0,1'b1,3'd2,18'h23800,16'h0030,2'd0,4'd3},
        // R4 block erase
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd4},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd4},
        {18'h05555,16'h0080,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd4},
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd4},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd4},
        {18'h1ABCD,16'h0050,1'b0,1'b1,3'd3,18'h18000,16'h0050,2'd0,4'd4},
        // R5 chip erase
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd5},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd5},
        {18'h05555,16'h0080,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd5},
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd5},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd5},
        {18'h05555,16'h0010,1'b0,1'b1,3'd4,18'h00000,16'h0010,2'd0,4'd5},
        // R5 chip code at wrong address
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd5},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd5},
        {18'h05555,16'h0080,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd5},
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd5},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd5},
        {18'h01234,16'h0010,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd5},
        // R7 identification entry, R8 single exit
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd7},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd7},
        {18'h05555,16'h0090,1'b0,1'b0,3'd0,18'h0,16'h0,2'd1,4'd7},
        {18'h3FFFF,16'h00F0,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd8},
        // R7 query entry, R8 three-write exit
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd7},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd7},
        {18'h05555,16'h0098,1'b0,1'b0,3'd0,18'h0,16'h0,2'd2,4'd7},
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd2,4'd8},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd2,4'd8},
        {18'h05555,16'h00F0,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd8},
        // R9 stray write in identification mode
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd9},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd9},
        {18'h05555,16'h0090,1'b0,1'b0,3'd0,18'h0,16'h0,2'd1,4'd9},
        {18'h05555,16'h00BB,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd9},
        // R9 wrong fifth step restarts the sequence
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd9},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd9},
        {18'h05555,16'h0080,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd9},
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd9},
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd9},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd9},
        {18'h05555,16'h0030,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd9},
        // R10 busy write inside an unlock
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd10},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd10},
        {18'h05555,16'h00F0,1'b1,1'b0,3'd0,18'h0,16'h0,2'd0,4'd10},
        {18'h05555,16'h00A0,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd10},
        {18'h00100,16'hCAFE,1'b0,1'b1,3'd1,18'h00100,16'hCAFE,2'd0,4'd10},
        // R10 busy exit ignored in identification mode
        {18'h05555,16'h00AA,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd10},
        {18'h02AAA,16'h0055,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd10},
        {18'h05555,16'h0090,1'b0,1'b0,3'd0,18'h0,16'h0,2'd1,4'd10},
        {18'h3FFFF,16'h00F0,1'b1,1'b0,3'd0,18'h0,16'h0,2'd1,4'd10},
        {18'h00000,16'h00F0,1'b0,1'b0,3'd0,18'h0,16'h0,2'd0,4'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy = 1'b0;
    logic [17:0] rd_addr = '0;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [17:0] req_addr;
    logic [15:0] req_data;
    logic [1:0]  mode;
    logic [15:0] id_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    nor_cmd_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .rd_addr   (rd_addr),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .mode      (mode),
        .id_data   (id_data)
    );

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_one(input logic [17:0] a, input logic [15:0] d, input logic b);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        busy    = b;
        @(negedge clk);
        wr_stb = 1'b0;
        busy   = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_val("R1 mode", 32'(mode), 32'd0);
        check_val("R1 req_valid", 32'(req_valid), 32'd0);
        check_val("R1 id_data", 32'(id_data), 32'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            write_one(v[78:61], v[60:45], v[44]);
            checks++;
            if (req_valid !== v[43] || mode !== v[5:4] ||
                (v[43] && (req_op !== v[42:40] || req_addr !== v[39:22] || req_data !== v[21:6]))) begin
                fails++;
                $display("FAIL R%0d vec %0d: valid=%0b op=%0d addr=%h data=%h mode=%0d expected valid=%0b op=%0d addr=%h data=%h mode=%0d",
                         v[3:0], i, req_valid, req_op, req_addr, req_data, mode,
                         v[43], v[42:40], v[39:22], v[21:6], v[5:4]);
            end
            if (v[43]) begin
                @(negedge clk);
                // R12 pulse lasts one cycle
                check_val("R12 req_valid after pulse", 32'(req_valid), 32'd0);
            end
        end

        // R11 identification reads
        write_one(18'h05555, 16'h00AA, 1'b0);
        write_one(18'h02AAA, 16'h0055, 1'b0);
        write_one(18'h05555, 16'h0090, 1'b0);
        rd_addr = 18'h00000; #1;
        check_val("R11 manufacturer code", 32'(id_data), 32'h00BF);
        rd_addr = 18'h00001; #1;
        check_val("R11 device code", 32'(id_data), 32'h272F);
        rd_addr = 18'h00002; #1;
        check_val("R11 other word", 32'(id_data), 32'h0000);
        rd_addr = 18'h20001; #1;
        check_val("R11 high address", 32'(id_data), 32'h0000);
        write_one(18'h12345, 16'h00F0, 1'b0);
        rd_addr = 18'h00001; #1;
        check_val("R11 after exit", 32'(id_data), 32'h0000);
        // R11 query mode gives no code
        write_one(18'h05555, 16'h00AA, 1'b0);
        write_one(18'h02AAA, 16'h0055, 1'b0);
        write_one(18'h05555, 16'h0098, 1'b0);
        rd_addr = 18'h00000; #1;
        check_val("R11 query mode", 32'(id_data), 32'h0000);
        check_val("R7 query mode value", 32'(mode), 32'd2);

        // R1 reset mid-mode returns to read
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_val("R1 mode after reset", 32'(mode), 32'd0);

        done = 1'b1;
        finish_run();
    end

endmodule